// File: doc/BRIEF.md
# Banked Register File with Three-Way Operand Resolution

This block is the data-memory side of a small microcontroller core. It holds sixteen global registers and sixteen banks of sixteen general registers each. A 5-bit operand taken from an instruction is mapped onto that storage in one of three ways. The choice depends on the operand value and on an 8-bit pointer register that lives in global slot 04h. The global slots act as plain byte storage. Timer, program counter, port and status side effects belong to other blocks.

The resolver works in one of three modes. In MODE_INDIRECT (operand exactly 00h), the whole pointer is the target address. In MODE_DIRECT (operand 01h to 0Fh), the operand selects a global slot. In MODE_WINDOW (operand bit 4 set), the pointer's upper nibble picks a bank and the operand's lower nibble picks a register inside it. The resolver reports one of three target kinds: TGT_GLOBAL, TGT_BANK or TGT_NONE. An access takes one clock. The pointer can be reloaded whole through its own port, have only its bank nibble replaced, or be written as global slot 04h through an ordinary access.

Top module: `banked_regfile`

## Requirements
- R1: After reset the pointer is 00h, every global and banked register holds 00h, `acc_rdata` is 00h and `acc_void` is 0.
- R2: An operand from 01h to 0Fh (bit 4 clear, not zero) reads or writes the global slot equal to the operand, whatever the pointer holds. No banked register is touched.
- R3: An operand with bit 4 set reaches bank ptr[7:4], register operand[3:0]. The pointer's lower nibble has no effect, and no global slot is touched.
- R4: Operand 00h with pointer 01h to 0Fh reaches the global slot equal to the pointer. A pointer of 10h to FFh reaches bank ptr[7:4], register ptr[3:0]. Bank 0 is therefore never reached this way.
- R5: Operand 00h with pointer 00h reads as 00h and discards a write, and `acc_void` is 1 after that access. Every other access leaves `acc_void` at 0.
- R6: Global slot 04h is the pointer. Reading it returns the pointer, and writing it replaces all eight pointer bits. The very next access resolves with the new value.
- R7: `ptr_ld` loads the whole pointer from `ptr_val`. `bank_sel_ld` replaces ptr[7:4] with `bank_sel_val` and keeps ptr[3:0]. When several fire in one cycle, an access write to slot 04h wins over `ptr_ld`, and `ptr_ld` wins over `bank_sel_ld`.
- R8: `acc_rdata` and `acc_void` are registered at the clock edge where `acc_en` is high. A read returns the content held before that edge, including a pointer that is reloaded at the same edge. A write updates storage at that edge and leaves `acc_rdata` unchanged. While `acc_en` is low, both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access strobe for this cycle |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_opnd | input | 5 | Instruction operand field |
| acc_wdata | input | 8 | Write data |
| ptr_ld | input | 1 | Load whole pointer |
| ptr_val | input | 8 | Pointer load value |
| bank_sel_ld | input | 1 | Replace pointer bank nibble |
| bank_sel_val | input | 4 | New bank nibble |
| acc_rdata | output | 8 | Registered read data |
| acc_void | output | 1 | Registered flag for an access with no target |

## Verification
The assertions take it that every input is a known value at each rising edge after reset. They also take it that the pointer, bank and access strobes may fire in any combination, since the priority rule covers every overlap. The pointer properties assume an 8-bit data path, so a write to slot 04h carries all pointer bits. The stimulus changes inputs only at falling edges and drives 0 on all of them during reset. It deliberately combines loads and slot-04h writes in single cycles so that the priority cases fall inside the assumed input space.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

    // How an operand is interpreted
    typedef enum logic [1:0] {
        MODE_INDIRECT = 2'd0,
        MODE_DIRECT   = 2'd1,
        MODE_WINDOW   = 2'd2
    } acc_mode_e;

    // What the operand finally lands on
    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_GLOBAL = 2'd1,
        TGT_BANK   = 2'd2
    } tgt_kind_e;

endpackage

// File: rtl/bfr_resolver.sv
module bfr_resolver
    import bfr_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int BANK_W = 4,
    localparam int PTR_W = BANK_W + REG_W
) (
    input  logic [REG_W:0]    opnd,
    input  logic [PTR_W-1:0]  ptr,
    output acc_mode_e         mode,
    output tgt_kind_e         kind,
    output logic [REG_W-1:0]  gidx,
    output logic [BANK_W-1:0] bank,
    output logic [REG_W-1:0]  breg
);

    logic [BANK_W-1:0] ptr_hi;
    logic [REG_W-1:0]  ptr_lo;

    assign ptr_hi = ptr[PTR_W-1:REG_W];
    assign ptr_lo = ptr[REG_W-1:0];

    // Mode selection from the operand alone
    always_comb begin
        if (opnd == '0) begin
            mode = MODE_INDIRECT;
        end else if (opnd[REG_W]) begin
            mode = MODE_WINDOW;
        end else begin
            mode = MODE_DIRECT;
        end
    end

    // Target resolution per mode
    always_comb begin
        kind = TGT_NONE;
        gidx = '0;
        bank = '0;
        breg = '0;
        unique case (mode)
            MODE_INDIRECT: begin
                if (ptr_hi != '0) begin
                    kind = TGT_BANK;
                    bank = ptr_hi;
                    breg = ptr_lo;
                end else if (ptr_lo != '0) begin
                    kind = TGT_GLOBAL;
                    gidx = ptr_lo;
                end else begin
                    kind = TGT_NONE;
                end
            end
            MODE_DIRECT: begin
                kind = TGT_GLOBAL;
                gidx = opnd[REG_W-1:0];
            end
            MODE_WINDOW: begin
                kind = TGT_BANK;
                bank = ptr_hi;
                breg = opnd[REG_W-1:0];
            end
            default: kind = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/bfr_globals.sv
module bfr_globals #(
    parameter int DATA_W   = 8,
    parameter int REG_W    = 4,
    parameter int BANK_W   = 4,
    parameter int PTR_SLOT = 4,
    localparam int PTR_W   = BANK_W + REG_W,
    localparam int NREG    = 1 << REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ptr_ld,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              bank_ld,
    input  logic [BANK_W-1:0] bank_val,
    output logic [DATA_W-1:0] rdata,
    output logic [PTR_W-1:0]  ptr
);

    logic [PTR_W-1:0]  ptr_q;
    logic              ptr_wr;
    logic [DATA_W-1:0] slot_rd [NREG];

    assign ptr_wr = wr_en && (idx == REG_W'(PTR_SLOT));

    // Pointer register: access write, then full load, then bank nibble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_wr) begin
            ptr_q <= PTR_W'(wdata);
        end else if (ptr_ld) begin
            ptr_q <= ptr_val;
        end else if (bank_ld) begin
            ptr_q <= {bank_val, ptr_q[REG_W-1:0]};
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g == 0) begin : g_void
            assign slot_rd[g] = '0;
        end else if (g == PTR_SLOT) begin : g_ptr
            assign slot_rd[g] = DATA_W'(ptr_q);
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (idx == REG_W'(g))) begin
                    q <= wdata;
                end
            end
            assign slot_rd[g] = q;
        end
    end

    assign rdata = slot_rd[idx];
    assign ptr   = ptr_q;

    AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_wr && !ptr_ld && !bank_ld) |=> $stable(ptr_q)); // R7
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_ld && !ptr_wr) |=> (ptr_q == $past(ptr_val))); // R7
    AST_BANK_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ld && !ptr_ld && !ptr_wr) |=>
        (ptr_q == {$past(bank_val), $past(ptr_q[REG_W-1:0])})); // R7

endmodule

// File: rtl/bfr_bank.sv
module bfr_bank #(
    parameter int DATA_W = 8,
    parameter int REG_W  = 4,
    localparam int NREG  = 1 << REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cell_rd [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (idx == REG_W'(r))) begin
                q <= wdata;
            end
        end
        assign cell_rd[r] = q;
    end

    assign rdata = cell_rd[idx];

endmodule

// File: rtl/bfr_banks.sv
module bfr_banks #(
    parameter int DATA_W = 8,
    parameter int REG_W  = 4,
    parameter int BANK_W = 4,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [NBANK-1:0]  bank_wr;
    logic [DATA_W-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_wr[b] = wr_en && (bank == BANK_W'(b));
        bfr_bank #(
            .DATA_W(DATA_W),
            .REG_W (REG_W)
        ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(bank_wr[b]),
            .idx  (idx),
            .wdata(wdata),
            .rdata(bank_rd[b])
        );
    end

    assign rdata = bank_rd[bank];

    AST_ONE_BANK_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr)); // R3

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bfr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int REG_W    = 4,
    parameter int BANK_W   = 4,
    parameter int PTR_SLOT = 4,
    localparam int PTR_W   = BANK_W + REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [REG_W:0]    acc_opnd,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              ptr_ld,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              bank_sel_ld,
    input  logic [BANK_W-1:0] bank_sel_val,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_void
);

    acc_mode_e         mode;
    tgt_kind_e         kind;
    logic [REG_W-1:0]  gidx;
    logic [BANK_W-1:0] bank;
    logic [REG_W-1:0]  breg;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] glb_rd;
    logic [DATA_W-1:0] bnk_rd;
    logic [DATA_W-1:0] sel_rd;
    logic              glb_wr;
    logic              bnk_wr;
    logic [DATA_W-1:0] rdata_q;
    logic              void_q;

    bfr_resolver #(
        .REG_W (REG_W),
        .BANK_W(BANK_W)
    ) u_res (
        .opnd(acc_opnd),
        .ptr (ptr),
        .mode(mode),
        .kind(kind),
        .gidx(gidx),
        .bank(bank),
        .breg(breg)
    );

    assign glb_wr = acc_en && acc_we && (kind == TGT_GLOBAL);
    assign bnk_wr = acc_en && acc_we && (kind == TGT_BANK);

    bfr_globals #(
        .DATA_W  (DATA_W),
        .REG_W   (REG_W),
        .BANK_W  (BANK_W),
        .PTR_SLOT(PTR_SLOT)
    ) u_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (glb_wr),
        .idx     (gidx),
        .wdata   (acc_wdata),
        .ptr_ld  (ptr_ld),
        .ptr_val (ptr_val),
        .bank_ld (bank_sel_ld),
        .bank_val(bank_sel_val),
        .rdata   (glb_rd),
        .ptr     (ptr)
    );

    bfr_banks #(
        .DATA_W(DATA_W),
        .REG_W (REG_W),
        .BANK_W(BANK_W)
    ) u_bnk (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(bnk_wr),
        .bank (bank),
        .idx  (breg),
        .wdata(acc_wdata),
        .rdata(bnk_rd)
    );

    always_comb begin
        unique case (kind)
            TGT_GLOBAL: sel_rd = glb_rd;
            TGT_BANK:   sel_rd = bnk_rd;
            default:    sel_rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            void_q  <= 1'b0;
        end else if (acc_en) begin
            void_q <= (kind == TGT_NONE);
            if (!acc_we) begin
                rdata_q <= sel_rd;
            end
        end
    end

    assign acc_rdata = rdata_q;
    assign acc_void  = void_q;

    AST_VOID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_opnd == '0 && ptr == '0) |=> acc_void); // R5
    AST_VOID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && acc_opnd == '0 && ptr == '0) |=> (acc_rdata == '0)); // R5
    AST_REAL_NO_VOID: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_opnd != '0) |=> !acc_void); // R5
    AST_WINDOW_NO_VOID: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && mode == MODE_WINDOW) |=> !acc_void); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> ($stable(acc_rdata) && $stable(acc_void))); // R8
    AST_WRITE_KEEPS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we) |=> $stable(acc_rdata)); // R8
    AST_SLOT_PTR_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && acc_opnd == (REG_W+1)'(PTR_SLOT)) |=>
        (ptr == PTR_W'($past(acc_wdata)))); // R6
    AST_SLOT_PTR_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && acc_opnd == (REG_W+1)'(PTR_SLOT)) |=>
        (acc_rdata == DATA_W'($past(ptr)))); // R6

endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_en, acc_we, ptr_ld, bank_sel_ld;
    logic [4:0] acc_opnd;
    logic [7:0] acc_wdata, ptr_val;
    logic [3:0] bank_sel_val;
    logic [7:0] acc_rdata;
    logic       acc_void;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    bit done = 0;

    // Behavioural reference state
    logic [7:0] m_glb [16];
    logic [7:0] m_bnk [256];
    logic [7:0] m_ptr;
    logic [7:0] m_rd;
    logic       m_void;

    always #10 clk = ~clk;

    banked_regfile u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .acc_we      (acc_we),
        .acc_opnd    (acc_opnd),
        .acc_wdata   (acc_wdata),
        .ptr_ld      (ptr_ld),
        .ptr_val     (ptr_val),
        .bank_sel_ld (bank_sel_ld),
        .bank_sel_val(bank_sel_val),
        .acc_rdata   (acc_rdata),
        .acc_void    (acc_void)
    );

    // Flat target: -1 none, 0..15 global slot, 16+n banked cell n
    function automatic int ref_target(input logic [4:0] op, input logic [7:0] p);
        if (op == 5'd0) begin
            if (p == 8'd0) return -1;
            if (p < 8'd16) return int'(p);
            return 16 + int'(p);
        end
        if (op < 5'd16) return int'(op);
        return 16 + int'(p & 8'hF0) + int'(op & 5'h0F);
    endfunction

    function automatic logic [7:0] ref_read(input int t);
        if (t < 0) return 8'h00;
        if (t == 4) return m_ptr;
        if (t < 16) return m_glb[t];
        return m_bnk[t - 16];
    endfunction

    task automatic check(input string req);
        checks++;
        if (acc_rdata !== m_rd || acc_void !== m_void) begin
            errors++;
            $display("FAIL %s: rdata=%02h void=%0b expected rdata=%02h void=%0b",
                     req, acc_rdata, acc_void, m_rd, m_void);
        end
    endtask

    task automatic cyc(input logic en, input logic we, input logic [4:0] op,
                       input logic [7:0] wd, input logic fl, input logic [7:0] fv,
                       input logic bl, input logic [3:0] bv, input string req);
        int t;
        logic ptr_hit;
        acc_en = en; acc_we = we; acc_opnd = op; acc_wdata = wd;
        ptr_ld = fl; ptr_val = fv; bank_sel_ld = bl; bank_sel_val = bv;
        @(posedge clk);
        t = ref_target(op, m_ptr);
        ptr_hit = 1'b0;
        if (en) begin
            m_void = (t < 0);
            if (!we) m_rd = ref_read(t);
            else if (t == 4) ptr_hit = 1'b1;
            else if (t > 0 && t < 16) m_glb[t] = wd;
            else if (t >= 16) m_bnk[t - 16] = wd;
        end
        if (ptr_hit) m_ptr = wd;
        else if (fl) m_ptr = fv;
        else if (bl) m_ptr = {bv, m_ptr[3:0]};
        @(negedge clk);
        check(req);
    endtask

    task automatic rd(input logic [4:0] op, input string req);
        cyc(1, 0, op, 8'h00, 0, 8'h00, 0, 4'h0, req);
    endtask

    task automatic wr(input logic [4:0] op, input logic [7:0] d, input string req);
        cyc(1, 1, op, d, 0, 8'h00, 0, 4'h0, req);
    endtask

    task automatic setp(input logic [7:0] p, input string req);
        cyc(0, 0, 5'd0, 8'h00, 1, p, 0, 4'h0, req);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt >= 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc_cnt);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_glb[i] = 8'h00;
        for (int i = 0; i < 256; i++) m_bnk[i] = 8'h00;
        m_ptr = 8'h00; m_rd = 8'h00; m_void = 1'b0;
        rst_n = 1'b0;
        acc_en = 0; acc_we = 0; acc_opnd = 0; acc_wdata = 0;
        ptr_ld = 0; ptr_val = 0; bank_sel_ld = 0; bank_sel_val = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1");

        // R1: everything cleared
        setp(8'h3C, "R1");
        for (int r = 0; r < 16; r++) rd(5'(16 + r), "R1");
        for (int i = 1; i < 16; i++) rd(5'(i), "R1");

        // R3: fill every bank through the window, low nibble varied
        for (int b = 0; b < 16; b++) begin
            setp({4'(b), 4'(b) ^ 4'h9}, "R3");
            for (int r = 0; r < 16; r++)
                wr(5'(16 + r), 8'((b * 16 + r)) ^ 8'hA5, "R3");
        end
        // R2: fill globals except the pointer slot
        for (int i = 1; i < 16; i++)
            if (i != 4) wr(5'(i), 8'h40 + 8'(i * 3), "R2");

        // R3: read back with a different low nibble, bank chosen by nibble load
        for (int b = 0; b < 16; b++) begin
            cyc(0, 0, 5'd0, 8'h00, 0, 8'h00, 1, 4'(b), "R7");
            for (int r = 0; r < 16; r++) rd(5'(16 + r), "R3");
        end

        // R2: direct reads under several pointer values
        setp(8'h00, "R2");
        for (int i = 1; i < 16; i++) rd(5'(i), "R2");
        setp(8'h37, "R2");
        for (int i = 1; i < 16; i++) rd(5'(i), "R2");
        setp(8'hFF, "R2");
        for (int i = 1; i < 16; i++) rd(5'(i), "R2");

        // R4 / R5: indirect sweep over every pointer value
        for (int p = 0; p < 256; p++) begin
            setp(8'(p), "R7");
            rd(5'd0, (p == 0) ? "R5" : "R4");
        end

        // R4: indirect writes, read back through other modes
        setp(8'h13, "R4"); wr(5'd0, 8'hEC, "R4");
        cyc(0, 0, 5'd0, 8'h00, 0, 8'h00, 1, 4'h1, "R4"); rd(5'h13, "R4");
        setp(8'hFF, "R4"); wr(5'd0, 8'h3D, "R4"); rd(5'h1F, "R4");
        setp(8'h5C, "R4"); wr(5'd0, 8'h71, "R4"); rd(5'h1C, "R4");
        setp(8'h07, "R4"); wr(5'd0, 8'h9E, "R4"); rd(5'h07, "R4");
        setp(8'h09, "R4"); rd(5'd0, "R4");
        cyc(0, 0, 5'd0, 8'h00, 0, 8'h00, 1, 4'h0, "R4");
        for (int r = 0; r < 16; r++) rd(5'(16 + r), "R4");

        // R5: write through a zero pointer is discarded
        setp(8'h00, "R5");
        wr(5'd0, 8'h99, "R5");
        rd(5'd0, "R5");
        for (int i = 1; i < 16; i++) rd(5'(i), "R5");
        for (int r = 0; r < 16; r++) rd(5'(16 + r), "R5");

        // R6: slot 04h is the pointer, effective at the next access
        wr(5'd4, 8'h2B, "R6");
        rd(5'h15, "R6");
        rd(5'd4, "R6");
        setp(8'h04, "R6");
        wr(5'd0, 8'h61, "R6");
        rd(5'd0, "R6");
        rd(5'd4, "R6");

        // R7: load priorities
        cyc(0, 0, 5'd0, 8'h00, 1, 8'h34, 1, 4'hE, "R7"); rd(5'd4, "R7");
        cyc(0, 0, 5'd0, 8'h00, 0, 8'h00, 1, 4'hA, "R7"); rd(5'd4, "R7");
        cyc(1, 1, 5'd4, 8'h77, 1, 8'h11, 1, 4'h2, "R7"); rd(5'd4, "R7");
        rd(5'h1B, "R7");

        // R8: timing and hold behaviour
        rd(5'h15, "R8");
        wr(5'h15, 8'hD2, "R8");
        cyc(0, 0, 5'd0, 8'h00, 0, 8'h00, 0, 4'h0, "R8");
        cyc(0, 0, 5'd0, 8'h00, 0, 8'h00, 0, 4'h0, "R8");
        rd(5'h15, "R8");
        cyc(1, 0, 5'd4, 8'h00, 1, 8'h50, 0, 4'h0, "R8");
        rd(5'd4, "R8");
        setp(8'h00, "R8");
        rd(5'd0, "R8");
        cyc(0, 0, 5'd0, 8'h00, 1, 8'h22, 0, 4'h0, "R8");
        rd(5'd3, "R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule